// File: doc/BRIEF.md
# Register-Mapped Time-of-Day Clock

This block keeps a seconds-and-nanoseconds time value for a timing card. The value moves forward by a fixed nanosecond step on each pulse of a local reference tick. Software reaches the block over a simple 32-bit register bus with a one-cycle registered read path.

To read the time, software writes a request bit in the control word. The block then captures seconds and nanoseconds together into a pair of holding registers and raises a done flag. To set the time, software stages seconds and nanoseconds and then writes a one-shot control bit. A second one-shot bit adds a staged nanosecond offset to the running time. Both one-shot bits act only while the clock is enabled and the register source is the active source.

The block also reports a registered in-sync input, a requested and an active clock source, and a constant version word.

Top module: `tod_clock_core`

## Requirements
- R1: After reset the control, status, select, time and staging registers all read zero, the clock is disabled, and the time does not advance.
- R2: Control bit 0 is the enable and reads back as written. While it is 1, each cycle with `tick_in` high adds `NS_INC` (default 8) to the nanosecond count. While it is 0, the count holds.
- R3: Writing control with bit 30 set clears bit 31 and shows bit 30 as 1. On the next clock edge the block copies the running seconds and nanoseconds into the time_sec (0x14) and time_ns (0x10) registers in the same cycle, clears bit 30 and sets bit 31. Bit 31 stays set until the next request.
- R4: Writing control with bit 1 set shows bit 1 as 1 for one cycle. On the next edge, the running time is loaded from adjust_sec (0x24) and adjust_ns (0x20), but only if the active source is 6 (register). Otherwise the time is left unchanged. Bit 1 then reads 0.
- R5: The nanosecond count stays below 1,000,000,000. A step that reaches that value wraps the count by subtracting 1,000,000,000 and adds one to the seconds.
- R6: Select (0x08) holds a 3-bit requested source in bits [2:0], encoded 0 none, 1 time-of-day serial, 2 IRIG, 3 pulse-per-second, 4 PTP, 5 RTC, 6 register, 7 external. Bits [18:16] show the active source: the requested source while the clock is enabled, and 0 otherwise. All other bits read 0.
- R7: A staged nanosecond value of 1,000,000,000 or more is loaded as 999,999,999.
- R8: Writing control with bit 2 set adds offset_ns (0x30) to the running time on the next edge, with the same clamp and carry rules. It does this only when the active source is 6 and no time load happens in that same cycle. offset_window_ns (0x34) is stored and read back.
- R9: Status (0x04) bit 0 shows `sync_in` through one register stage.
- R10: Version (0x0C) reads as major in [31:24], minor in [23:16] and build in [15:0], taken from parameters.
- R11: `bus_rdata` shows the register addressed in the previous cycle. Unmapped addresses read zero.
- R12: A time load or offset add in a given cycle takes priority over a tick in that cycle, so the tick is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_in | input | 1 | Nanosecond reference tick |
| sync_in | input | 1 | In-sync indication from the reference |

## Verification
A corrupted nanosecond count shows up in the next snapshot, one cycle after the request. A missed wrap shows up in the same way, as a seconds value one short of the expected value. A wrong pending or done flag shows up on the very next control read. The bench predicts the read data for every cycle from its own model of the register file and counter, so a divergence is caught in the cycle it first reaches `bus_rdata`. Gating errors on the source check are caught by loads and offsets that are issued under a non-register source and must leave the time unchanged.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam logic [DATA_W-1:0] NS_PER_SEC = 32'd1_000_000_000;

  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] A_STATUS  = 8'h04;
  localparam logic [ADDR_W-1:0] A_SELECT  = 8'h08;
  localparam logic [ADDR_W-1:0] A_VERSION = 8'h0C;
  localparam logic [ADDR_W-1:0] A_SNAP_NS = 8'h10;
  localparam logic [ADDR_W-1:0] A_SNAP_S  = 8'h14;
  localparam logic [ADDR_W-1:0] A_STG_NS  = 8'h20;
  localparam logic [ADDR_W-1:0] A_STG_S   = 8'h24;
  localparam logic [ADDR_W-1:0] A_OFS_NS  = 8'h30;
  localparam logic [ADDR_W-1:0] A_OFS_WIN = 8'h34;

  localparam int B_EN   = 0;
  localparam int B_LOAD = 1;
  localparam int B_OFS  = 2;
  localparam int B_REQ  = 30;
  localparam int B_DONE = 31;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0, SRC_SERIAL = 3'd1, SRC_IRIG = 3'd2, SRC_PPS = 3'd3,
    SRC_PTP  = 3'd4, SRC_RTC    = 3'd5, SRC_REG  = 3'd6, SRC_EXT = 3'd7
  } src_e;

  function automatic logic [DATA_W-1:0] clamp_ns(input logic [DATA_W-1:0] v);
    return (v >= NS_PER_SEC) ? (NS_PER_SEC - 32'd1) : v;
  endfunction
endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int NS_INC = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_sec,
  input  logic [DATA_W-1:0] load_ns,
  input  logic              shift,
  input  logic [DATA_W-1:0] shift_ns,
  output logic [DATA_W-1:0] ns_o,
  output logic [DATA_W-1:0] sec_o
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(NS_INC);

  logic [DATA_W-1:0] ns_q, sec_q;
  logic [DATA_W-1:0] step_sum, shift_sum;
  logic              advance;

  always_comb begin
    step_sum  = ns_q + STEP;
    shift_sum = ns_q + clamp_ns(shift_ns);
    advance   = en && tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else if (load) begin
      ns_q  <= clamp_ns(load_ns);
      sec_q <= load_sec;
    end else if (shift) begin
      if (shift_sum >= NS_PER_SEC) begin
        ns_q  <= shift_sum - NS_PER_SEC;
        sec_q <= sec_q + 32'd1;
      end else begin
        ns_q  <= shift_sum;
      end
    end else if (advance) begin
      if (step_sum >= NS_PER_SEC) begin
        ns_q  <= step_sum - NS_PER_SEC;
        sec_q <= sec_q + 32'd1;
      end else begin
        ns_q  <= step_sum;
      end
    end
  end

  assign ns_o  = ns_q;
  assign sec_o = sec_q;

  p_ns_below_limit_r5: assert property (@(posedge clk) disable iff (rst)
    ns_q < NS_PER_SEC);

  p_carry_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift && advance && (ns_q + STEP >= NS_PER_SEC))
      |=> (sec_q == $past(sec_q) + 32'd1));

  p_frozen_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift && !advance) |=> ($stable(ns_q) && $stable(sec_q)));

  p_load_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (ns_q <= NS_PER_SEC - 32'd1));
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] cur_ns,
  input  logic [DATA_W-1:0] cur_sec,
  output logic              pend_o,
  output logic              done_o,
  output logic [DATA_W-1:0] snap_ns_o,
  output logic [DATA_W-1:0] snap_sec_o
);
  logic pend_q, done_q;
  logic [DATA_W-1:0] snap_ns_q, snap_sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      done_q     <= 1'b0;
      snap_ns_q  <= '0;
      snap_sec_q <= '0;
    end else begin
      if (pend_q) begin
        snap_ns_q  <= cur_ns;
        snap_sec_q <= cur_sec;
      end
      if (req_wr) begin
        pend_q <= 1'b1;
        done_q <= 1'b0;
      end else if (pend_q) begin
        pend_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign pend_o     = pend_q;
  assign done_o     = done_q;
  assign snap_ns_o  = snap_ns_q;
  assign snap_sec_o = snap_sec_q;

  p_done_follows_req_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(pend_q));

  p_snap_held_r3: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> ($stable(snap_ns_q) && $stable(snap_sec_q)));
endmodule

// File: rtl/tod_clock_core.sv
module tod_clock_core
  import tod_pkg::*;
#(
  parameter int          NS_INC    = 8,
  parameter logic [7:0]  VER_MAJOR = 8'd1,
  parameter logic [7:0]  VER_MINOR = 8'd2,
  parameter logic [15:0] VER_BUILD = 16'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_in,
  input  logic              sync_in
);
  localparam logic [DATA_W-1:0] VERSION_WORD = {VER_MAJOR, VER_MINOR, VER_BUILD};

  logic              en_q, load_req_q, ofs_req_q, sync_q;
  src_e              sel_q, active;
  logic [DATA_W-1:0] stg_ns_q, stg_sec_q, ofs_ns_q, ofs_win_q, rdata_q;
  logic              wr_ctrl, reg_src, do_load, do_shift;
  logic [DATA_W-1:0] cur_ns, cur_sec, snap_ns, snap_sec;
  logic              pend, done;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    active   = en_q ? sel_q : SRC_NONE;
    reg_src  = (active == SRC_REG);
    do_load  = load_req_q && reg_src;
    do_shift = ofs_req_q && reg_src && !load_req_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      load_req_q <= 1'b0;
      ofs_req_q  <= 1'b0;
      sync_q     <= 1'b0;
      sel_q      <= SRC_NONE;
      stg_ns_q   <= '0;
      stg_sec_q  <= '0;
      ofs_ns_q   <= '0;
      ofs_win_q  <= '0;
    end else begin
      sync_q     <= sync_in;
      load_req_q <= wr_ctrl && bus_wdata[B_LOAD];
      ofs_req_q  <= wr_ctrl && bus_wdata[B_OFS];
      if (wr_ctrl) en_q <= bus_wdata[B_EN];
      if (bus_wr) begin
        case (bus_addr)
          A_SELECT:  sel_q     <= src_e'(bus_wdata[2:0]);
          A_STG_NS:  stg_ns_q  <= bus_wdata;
          A_STG_S:   stg_sec_q <= bus_wdata;
          A_OFS_NS:  ofs_ns_q  <= bus_wdata;
          A_OFS_WIN: ofs_win_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  tod_counter #(.NS_INC(NS_INC)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .tick     (tick_in),
    .load     (do_load),
    .load_sec (stg_sec_q),
    .load_ns  (stg_ns_q),
    .shift    (do_shift),
    .shift_ns (ofs_ns_q),
    .ns_o     (cur_ns),
    .sec_o    (cur_sec)
  );

  tod_snapshot u_snap (
    .clk        (clk),
    .rst        (rst),
    .req_wr     (wr_ctrl && bus_wdata[B_REQ]),
    .cur_ns     (cur_ns),
    .cur_sec    (cur_sec),
    .pend_o     (pend),
    .done_o     (done),
    .snap_ns_o  (snap_ns),
    .snap_sec_o (snap_sec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (bus_addr)
        A_CTRL:    rdata_q <= {done, pend, 27'd0, ofs_req_q, load_req_q, en_q};
        A_STATUS:  rdata_q <= {31'd0, sync_q};
        A_SELECT:  rdata_q <= {13'd0, active, 13'd0, sel_q};
        A_VERSION: rdata_q <= VERSION_WORD;
        A_SNAP_NS: rdata_q <= snap_ns;
        A_SNAP_S:  rdata_q <= snap_sec;
        A_STG_NS:  rdata_q <= stg_ns_q;
        A_STG_S:   rdata_q <= stg_sec_q;
        A_OFS_NS:  rdata_q <= ofs_ns_q;
        A_OFS_WIN: rdata_q <= ofs_win_q;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

  p_load_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (load_req_q && !(wr_ctrl && bus_wdata[B_LOAD])) |=> !load_req_q);

  p_active_gated_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[B_EN]) |=> (active == SRC_NONE));
endmodule

// File: tb/tb_tod_clock_core.sv
module tb_tod_clock_core;
  localparam int INC = 8;
  localparam longint LIM = 64'd1_000_000_000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_in = 1'b0;
  logic        sync_in = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  tod_clock_core #(.NS_INC(INC), .VER_MAJOR(8'd1), .VER_MINOR(8'd2), .VER_BUILD(16'd7)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tick_in(tick_in), .sync_in(sync_in)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  longint m_ns, m_sec, m_sns, m_ssec, m_stg_ns, m_stg_sec, m_ofs, m_win;
  bit     m_en, m_ld, m_of, m_pend, m_done, m_sync, m_live;
  int     m_sel;
  logic [31:0] m_rd;

  function automatic longint clampv(longint v);
    return (v >= LIM) ? LIM - 1 : v;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00, 8'h10, 8'h14: return "R3";
      8'h04: return "R9";
      8'h08: return "R6";
      8'h0C: return "R10";
      8'h20, 8'h24: return "R4";
      8'h30, 8'h34: return "R8";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ns = 0; m_sec = 0; m_sns = 0; m_ssec = 0; m_stg_ns = 0; m_stg_sec = 0;
      m_ofs = 0; m_win = 0; m_en = 0; m_ld = 0; m_of = 0; m_pend = 0; m_done = 0;
      m_sync = 0; m_sel = 0; m_rd = '0; m_live = 1;
    end else begin
      int act;
      bit wc;
      longint s;
      act = m_en ? m_sel : 0;
      case (bus_addr)
        8'h00: m_rd = {m_done, m_pend, 27'd0, m_of, m_ld, m_en};
        8'h04: m_rd = {31'd0, m_sync};
        8'h08: m_rd = (act << 16) | m_sel;
        8'h0C: m_rd = 32'h0102_0007;
        8'h10: m_rd = 32'(m_sns);
        8'h14: m_rd = 32'(m_ssec);
        8'h20: m_rd = 32'(m_stg_ns);
        8'h24: m_rd = 32'(m_stg_sec);
        8'h30: m_rd = 32'(m_ofs);
        8'h34: m_rd = 32'(m_win);
        default: m_rd = '0;
      endcase
      if (m_pend) begin m_sns = m_ns; m_ssec = m_sec; end
      if (act == 6 && m_ld) begin
        m_ns = clampv(m_stg_ns); m_sec = m_stg_sec;
      end else if (act == 6 && m_of) begin
        s = m_ns + clampv(m_ofs);
        if (s >= LIM) begin m_ns = s - LIM; m_sec = (m_sec + 1) & 32'hFFFF_FFFF; end
        else m_ns = s;
      end else if (m_en && tick_in) begin
        s = m_ns + INC;
        if (s >= LIM) begin m_ns = s - LIM; m_sec = (m_sec + 1) & 32'hFFFF_FFFF; end
        else m_ns = s;
      end
      wc = bus_wr && bus_addr == 8'h00;
      if (wc && bus_wdata[30]) begin m_pend = 1; m_done = 0; end
      else if (m_pend) begin m_pend = 0; m_done = 1; end
      m_ld = wc && bus_wdata[1];
      m_of = wc && bus_wdata[2];
      if (wc) m_en = bus_wdata[0];
      m_sync = sync_in;
      if (bus_wr) begin
        case (bus_addr)
          8'h08: m_sel = int'(bus_wdata[2:0]);
          8'h20: m_stg_ns = longint'(bus_wdata);
          8'h24: m_stg_sec = longint'(bus_wdata);
          8'h30: m_ofs = longint'(bus_wdata);
          8'h34: m_win = longint'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && m_live) begin
      n_checks++;
      if (bus_rdata !== m_rd) begin
        n_fail++;
        $display("FAIL %s per-cycle addr %h: actual %h expected %h",
                 tag_of(bus_addr), bus_addr, bus_rdata, m_rd);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic snap(output logic [31:0] s, output logic [31:0] n);
    wr(8'h00, 32'h4000_0001);
    rd(8'h14, s);
    rd(8'h10, n);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, s, n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    rd(8'h00, v);  check("R1 control after reset", v, 32'h0);
    rd(8'h14, v);  check("R1 seconds after reset", v, 32'h0);
    rd(8'h0C, v);  check("R10 version", v, 32'h0102_0007);
    rd(8'h18, v);  check("R11 gap reads zero", v, 32'h0);

    wr(8'h08, 32'h6);
    rd(8'h08, v);  check("R6 select disabled", v, 32'h0000_0006);
    wr(8'h00, 32'h1);
    rd(8'h00, v);  check("R2 enable readback", v, 32'h1);
    rd(8'h08, v);  check("R6 select enabled", v, 32'h0006_0006);

    tick_in = 1'b1; repeat (5) @(posedge clk); #1 tick_in = 1'b0;
    snap(s, n);    check("R2 counting ns", n, 32'd40);
    rd(8'h00, v);  check("R3 done flag", v, 32'h8000_0001);

    wr(8'h20, 32'hFFFF_FFFF); wr(8'h24, 32'd9); wr(8'h00, 32'h3);
    snap(s, n);    check("R7 clamped ns", n, 32'd999_999_999);
    check("R4 loaded seconds", s, 32'd9);

    wr(8'h20, 32'd999_999_995); wr(8'h00, 32'h3);
    @(posedge clk); #1 tick_in = 1'b1;
    @(posedge clk); #1 tick_in = 1'b0;
    snap(s, n);    check("R5 wrap ns", n, 32'd3);
    check("R5 carry seconds", s, 32'd10);

    wr(8'h30, 32'd999_999_998); wr(8'h34, 32'd1234); wr(8'h00, 32'h5);
    snap(s, n);    check("R8 offset ns", n, 32'd1);
    check("R8 offset carry", s, 32'd11);
    rd(8'h34, v);  check("R8 window readback", v, 32'd1234);

    wr(8'h08, 32'h3); wr(8'h20, 32'd5); wr(8'h24, 32'd100); wr(8'h00, 32'h7);
    wr(8'h08, 32'h6);
    snap(s, n);    check("R4 no load off-source ns", n, 32'd1);
    check("R4 no load off-source sec", s, 32'd11);

    wr(8'h20, 32'd100); wr(8'h24, 32'd0);
    tick_in = 1'b1;
    wr(8'h00, 32'h3);
    @(posedge clk); #1 tick_in = 1'b0;
    snap(s, n);    check("R12 load beats tick", n, 32'd100);

    wr(8'h00, 32'h0);
    tick_in = 1'b1; repeat (4) @(posedge clk); #1 tick_in = 1'b0;
    wr(8'h00, 32'h4000_0000);
    rd(8'h10, n);  check("R2 frozen when disabled", n, 32'd100);
    rd(8'h08, v);  check("R6 active none when disabled", v, 32'h0000_0006);

    sync_in = 1'b1;
    rd(8'h04, v);  check("R9 sync status", v, 32'h1);
    sync_in = 1'b0;

    wr(8'h00, 32'h1);
    for (int k = 0; k < 300; k++) begin
      @(posedge clk); #1;
      tick_in = k[0];
      bus_addr = (k % 3 == 0) ? 8'h10 : 8'h00;
      bus_wr = (k % 37 == 5);
      bus_wdata = 32'h4000_0001;
    end
    bus_wr = 1'b0; tick_in = 1'b0;
    repeat (3) @(posedge clk);
    #1 finish_run();
  end
endmodule